// File: doc/BRIEF.md
# Bus Traffic Performance Counter Unit

This block watches one bus port and counts its data traffic. It holds one free-running cycle counter and four event counters. Each event counter picks its source through an event-type register. Counters 0 to 2 are 32 bits wide. Counter 3 is 40 bits wide and is read as a low word and a high byte. Software programs and reads the unit through an APB-style register slave. Two single-cycle strobe inputs mark a read data beat and a write data beat.

A typical measurement runs in four steps. Software selects the event codes and sets the enables. It then sets the global enable and clears the counters through the control register. To take a snapshot, it clears the global enable, which freezes every counter, and then reads the values. Only manual start is implemented. The automatic and conditional-interrupt start modes can be written and read back, but while either is selected no counter moves.

The event counters are `EV_WIDTH` bits wide, at most 32. Counter 3 is `WIDE_WIDTH` bits wide, from 33 to 40. The cycle counter is `CYC_WIDTH` bits wide, at most 32. The defaults are 32, 40 and 32.

Top module: `bus_perf_monitor`

## Requirements
- R1: Control register at offset 0x04: bit 0 is the global enable and bits 21:20 are the start mode (0 manual, 1 auto, 2 conditional). Both read back as written. Bits 1 and 2 are reset pulses and always read as zero.
- R2: Writing ones to offset 0x08 sets enable bits and writing ones to offset 0x0C clears them. Zero bits leave enables unchanged. Bits 3:0 enable event counters 0 to 3 and bit 31 enables the cycle counter. Both offsets read back the enable vector.
- R3: A counter advances only when the global enable is set, the start mode is 0 and its own enable bit is set. Otherwise it holds its value.
- R4: Event-type registers sit at 0x200 + 4*n and read back their low 8 bits. Code 0x04 counts read beats and code 0x05 counts write beats. Counters 0, 1 and 2 are read at 0x34, 0x38 and 0x3C.
- R5: Counter 3 is read with its low 32 bits at 0x40 and its upper bits in the low byte of 0x44. Code 0x22 makes counter 3 count read and write beats together, adding two when both strobes arrive in the same cycle. On counters 0 to 2, code 0x22 counts nothing, and any other unlisted code counts nothing on any counter.
- R6: The cycle counter, read at 0x48, adds one in every cycle in which it is enabled under R3.
- R7: Writing a one to control bit 1 clears all event counters. Writing a one to control bit 2 clears the cycle counter. Writing ones to offset 0x2C clears the counters selected by bits 3:0 and bit 31. A clear takes priority over counting in the same cycle.
- R8: The flag register at 0x18 uses bits 3:0 for the event counters and bit 31 for the cycle counter. A bit is set when its counter steps past its maximum value. Writing a one to a bit clears it, but a wrap in the same cycle keeps it set.
- R9: Unmapped offsets, and the unimplemented offsets 0x1C to 0x30 including 0x2C, read as zero. Writes to unmapped offsets change nothing.
- R10: After reset every register and counter reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational on paddr |
| rdBeat | input | 1 | One read data beat this cycle |
| wrBeat | input | 1 | One write data beat this cycle |

## Verification
The hardest case to reach from the ports is the overflow flag. At full width, a counter would need billions of beats to wrap. The bench therefore builds the unit with 8-bit event counters and a 10-bit cycle counter, so a few hundred steady beats carry it past its maximum. While it does this, it also clears flags in cycles close to the wrap. Random register traffic mixed with random strobes then covers clears, start-mode changes and combined-mode double steps that land in the same cycles as counting.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int NUM_EV  = 4;
  localparam int CYC_BIT = 31;
  localparam int ADDR_W  = 12;

  localparam logic [7:0] EVT_RD   = 8'h04;
  localparam logic [7:0] EVT_WR   = 8'h05;
  localparam logic [7:0] EVT_BOTH = 8'h22;

  typedef enum logic [1:0] {
    MODE_MANUAL = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_COND   = 2'd2
  } startMode_t;

  // strobes from the register slave to the counting datapath
  typedef struct packed {
    logic [NUM_EV-1:0] evRun;
    logic              cycRun;
    logic [NUM_EV-1:0] evClr;
    logic              cycClr;
    logic [NUM_EV-1:0] rdSel;
    logic [NUM_EV-1:0] wrSel;
    logic [NUM_EV-1:0] flagClr;
    logic              cycFlagClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             clr,
  input  logic [1:0]       step,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  logic [WIDTH:0] sum;

  assign sum  = {1'b0, count} + {{(WIDTH-1){1'b0}}, step};
  assign wrap = run && !clr && sum[WIDTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    count <= '0;
    else if (clr) count <= '0;
    else if (run) count <= sum[WIDTH-1:0];
  end

  // R3: a stopped counter holds its value
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !clr) |=> $stable(count));

  // R7: a clear wins over counting
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));
endmodule

// File: rtl/perfmon_datapath.sv
module perfmon_datapath
  import perfmon_pkg::*;
#(
  parameter int EV_WIDTH   = 32,
  parameter int WIDE_WIDTH = 40,
  parameter int CYC_WIDTH  = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrlStrobes_t                       strb,
  input  logic                               rdBeat,
  input  logic                               wrBeat,
  output logic [NUM_EV-2:0][EV_WIDTH-1:0]    narrowCnt,
  output logic [WIDE_WIDTH-1:0]              wideCnt,
  output logic [CYC_WIDTH-1:0]               cycCnt,
  output logic [NUM_EV-1:0]                  evFlag,
  output logic                               cycFlag
);
  localparam int LAST = NUM_EV - 1;

  logic [NUM_EV-1:0][1:0] evStep;
  logic [NUM_EV-1:0]      evWrap;
  logic                   cycWrap;

  for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_ev
    assign evStep[gi] = {1'b0, strb.rdSel[gi] & rdBeat} + {1'b0, strb.wrSel[gi] & wrBeat};
    if (gi < LAST) begin : g_narrow
      perfmon_counter #(.WIDTH(EV_WIDTH)) cnt_i (
        .clk(clk), .rstN(rstN), .run(strb.evRun[gi]), .clr(strb.evClr[gi]),
        .step(evStep[gi]), .count(narrowCnt[gi]), .wrap(evWrap[gi]));
    end else begin : g_wide
      perfmon_counter #(.WIDTH(WIDE_WIDTH)) cnt_i (
        .clk(clk), .rstN(rstN), .run(strb.evRun[gi]), .clr(strb.evClr[gi]),
        .step(evStep[gi]), .count(wideCnt), .wrap(evWrap[gi]));
    end
  end

  perfmon_counter #(.WIDTH(CYC_WIDTH)) cyc_i (
    .clk(clk), .rstN(rstN), .run(strb.cycRun), .clr(strb.cycClr),
    .step(2'd1), .count(cycCnt), .wrap(cycWrap));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evFlag  <= '0;
      cycFlag <= 1'b0;
    end else begin
      evFlag  <= (evFlag & ~strb.flagClr) | evWrap;
      cycFlag <= (cycFlag & !strb.cycFlagClr) | cycWrap;
    end
  end

  // R8: a wrap always leaves its flag set, even against a clear
  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evWrap != '0) |=> ((evFlag & $past(evWrap)) == $past(evWrap)));

  // R6: the cycle counter steps by exactly one
  assert_cycle_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cycRun && !strb.cycClr) |=> (cycCnt == CYC_WIDTH'($past(cycCnt) + 1'b1)));
endmodule

// File: rtl/perfmon_regs.sv
module perfmon_regs
  import perfmon_pkg::*;
#(
  parameter int EV_WIDTH   = 32,
  parameter int WIDE_WIDTH = 40,
  parameter int CYC_WIDTH  = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            psel,
  input  logic                            penable,
  input  logic                            pwrite,
  input  logic [ADDR_W-1:0]               paddr,
  input  logic [31:0]                     pwdata,
  output logic [31:0]                     prdata,
  input  logic [NUM_EV-2:0][EV_WIDTH-1:0] narrowCnt,
  input  logic [WIDE_WIDTH-1:0]           wideCnt,
  input  logic [CYC_WIDTH-1:0]            cycCnt,
  input  logic [NUM_EV-1:0]               evFlag,
  input  logic                            cycFlag,
  output ctrlStrobes_t                    strb
);
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_ENSET   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ENCLR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_FLAG    = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_CLR     = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_CNT0    = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_WIDE_LO = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_WIDE_HI = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_CYC     = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_TYPE0   = 12'h200;
  localparam int HI_BITS = WIDE_WIDTH - 32;

  logic                   globalEn;
  logic [1:0]             startMode;
  logic [NUM_EV-1:0]      evEn;
  logic                   cycEn;
  logic [NUM_EV-1:0][7:0] evType;
  logic                   wrStb, ctrlWr, clrWr, flagWr, running;
  logic [NUM_EV:0]        enAll, wrMask;

  assign wrStb   = psel && penable && pwrite;
  assign ctrlWr  = wrStb && (paddr == OFF_CTRL);
  assign clrWr   = wrStb && (paddr == OFF_CLR);
  assign flagWr  = wrStb && (paddr == OFF_FLAG);
  assign running = globalEn && (startMode == MODE_MANUAL);
  assign enAll   = {cycEn, evEn};
  assign wrMask  = {pwdata[CYC_BIT], pwdata[NUM_EV-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      startMode <= MODE_MANUAL;
      evEn      <= '0;
      cycEn     <= 1'b0;
      evType    <= '0;
    end else if (wrStb) begin
      case (paddr)
        OFF_CTRL: begin
          globalEn  <= pwdata[0];
          startMode <= pwdata[21:20];
        end
        OFF_ENSET: begin
          evEn  <= evEn | pwdata[NUM_EV-1:0];
          cycEn <= cycEn | pwdata[CYC_BIT];
        end
        OFF_ENCLR: begin
          evEn  <= evEn & ~pwdata[NUM_EV-1:0];
          cycEn <= cycEn & !pwdata[CYC_BIT];
        end
        default: ;
      endcase
      for (int i = 0; i < NUM_EV; i++)
        if (paddr == OFF_TYPE0 + ADDR_W'(4 * i)) evType[i] <= pwdata[7:0];
    end
  end

  always_comb begin
    strb.evRun      = evEn & {NUM_EV{running}};
    strb.cycRun     = cycEn && running;
    strb.evClr      = ({NUM_EV{ctrlWr && pwdata[1]}}) | (clrWr ? pwdata[NUM_EV-1:0] : '0);
    strb.cycClr     = (ctrlWr && pwdata[2]) || (clrWr && pwdata[CYC_BIT]);
    strb.flagClr    = flagWr ? pwdata[NUM_EV-1:0] : '0;
    strb.cycFlagClr = flagWr && pwdata[CYC_BIT];
    for (int i = 0; i < NUM_EV; i++) begin
      strb.rdSel[i] = (evType[i] == EVT_RD) || ((i == NUM_EV - 1) && (evType[i] == EVT_BOTH));
      strb.wrSel[i] = (evType[i] == EVT_WR) || ((i == NUM_EV - 1) && (evType[i] == EVT_BOTH));
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      OFF_CTRL: begin
        prdata[0]     = globalEn;
        prdata[21:20] = startMode;
      end
      OFF_ENSET, OFF_ENCLR: begin
        prdata[NUM_EV-1:0] = evEn;
        prdata[CYC_BIT]    = cycEn;
      end
      OFF_FLAG: begin
        prdata[NUM_EV-1:0] = evFlag;
        prdata[CYC_BIT]    = cycFlag;
      end
      OFF_WIDE_LO: prdata = wideCnt[31:0];
      OFF_WIDE_HI: prdata[HI_BITS-1:0] = wideCnt[WIDE_WIDTH-1:32];
      OFF_CYC:     prdata[CYC_WIDTH-1:0] = cycCnt;
      default: ;
    endcase
    for (int i = 0; i < NUM_EV - 1; i++)
      if (paddr == OFF_CNT0 + ADDR_W'(4 * i)) prdata[EV_WIDTH-1:0] = narrowCnt[i];
    for (int i = 0; i < NUM_EV; i++)
      if (paddr == OFF_TYPE0 + ADDR_W'(4 * i)) prdata[7:0] = evType[i];
  end

  // R2: ones written to the set register turn their enables on
  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && paddr == OFF_ENSET) |=> ((enAll & $past(wrMask)) == $past(wrMask)));

  // R2: ones written to the clear register turn their enables off
  assert_enable_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && paddr == OFF_ENCLR) |=> ((enAll & $past(wrMask)) == '0));

  // R2: zero bits of either write leave the enables alone
  assert_enable_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && (paddr == OFF_ENSET || paddr == OFF_ENCLR))
      |=> ((enAll & ~$past(wrMask)) == ($past(enAll) & ~$past(wrMask))));
endmodule

// File: rtl/bus_perf_monitor.sv
module bus_perf_monitor
  import perfmon_pkg::*;
#(
  parameter int EV_WIDTH   = 32,
  parameter int WIDE_WIDTH = 40,
  parameter int CYC_WIDTH  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        rdBeat,
  input  logic        wrBeat
);
  ctrlStrobes_t                    strb;
  logic [NUM_EV-2:0][EV_WIDTH-1:0] narrowCnt;
  logic [WIDE_WIDTH-1:0]           wideCnt;
  logic [CYC_WIDTH-1:0]            cycCnt;
  logic [NUM_EV-1:0]               evFlag;
  logic                            cycFlag;

  perfmon_regs #(
    .EV_WIDTH(EV_WIDTH), .WIDE_WIDTH(WIDE_WIDTH), .CYC_WIDTH(CYC_WIDTH)
  ) regs_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .narrowCnt(narrowCnt), .wideCnt(wideCnt), .cycCnt(cycCnt),
    .evFlag(evFlag), .cycFlag(cycFlag), .strb(strb));

  perfmon_datapath #(
    .EV_WIDTH(EV_WIDTH), .WIDE_WIDTH(WIDE_WIDTH), .CYC_WIDTH(CYC_WIDTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdBeat(rdBeat), .wrBeat(wrBeat),
    .narrowCnt(narrowCnt), .wideCnt(wideCnt), .cycCnt(cycCnt),
    .evFlag(evFlag), .cycFlag(cycFlag));
endmodule

// File: tb/bus_perf_monitor_tb_top.sv
module bus_perf_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EVW   = 8;
  localparam int WIDEW = 40;
  localparam int CYCW  = 10;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        rdBeat = 0, wrBeat = 0;
  int          evMode = 0;  // 0 idle, 1 both, 2 read only, 3 write only, 4 random
  int          checks = 0, errors = 0;

  bus_perf_monitor #(.EV_WIDTH(EVW), .WIDE_WIDTH(WIDEW), .CYC_WIDTH(CYCW)) dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rdBeat(rdBeat), .wrBeat(wrBeat));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    case (evMode)
      1: begin rdBeat <= 1; wrBeat <= 1; end
      2: begin rdBeat <= 1; wrBeat <= 0; end
      3: begin rdBeat <= 0; wrBeat <= 1; end
      4: begin rdBeat <= 1'($urandom_range(0, 1)); wrBeat <= 1'($urandom_range(0, 1)); end
      default: begin rdBeat <= 0; wrBeat <= 0; end
    endcase
  end

  // reference model built from the requirements
  logic        mGlob, mCen, mCflag;
  logic [1:0]  mMode;
  logic [3:0]  mEn, mFlag;
  logic [7:0]  mType [4];
  logic [63:0] mCnt [4];
  logic [63:0] mCyc;

  function automatic int stepOf(int idx, logic [7:0] code, logic rd, logic wr);
    if (code == 8'h04) return int'(rd);
    if (code == 8'h05) return int'(wr);
    if (code == 8'h22 && idx == 3) return int'(rd) + int'(wr);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mGlob = 0; mCen = 0; mCflag = 0; mMode = 0; mEn = 0; mFlag = 0; mCyc = 0;
      for (int i = 0; i < 4; i++) begin mType[i] = 0; mCnt[i] = 0; end
    end else begin
      logic        wrOn, run, cycClr;
      logic [3:0]  evClr, setF;
      logic [63:0] sum, lim;
      wrOn   = psel && penable && pwrite;
      run    = mGlob && (mMode == 2'd0);
      evClr  = 4'h0; cycClr = 0; setF = 4'h0;
      if (wrOn && paddr == 12'h004) begin
        if (pwdata[1]) evClr = 4'hF;
        cycClr = pwdata[2];
      end
      if (wrOn && paddr == 12'h02C) begin
        evClr = evClr | pwdata[3:0];
        cycClr = cycClr | pwdata[31];
      end
      for (int i = 0; i < 4; i++) begin
        lim = 64'd1 << ((i == 3) ? WIDEW : EVW);
        if (evClr[i]) mCnt[i] = 0;
        else if (run && mEn[i]) begin
          sum = mCnt[i] + 64'(stepOf(i, mType[i], rdBeat, wrBeat));
          if (sum >= lim) begin setF[i] = 1; sum = sum - lim; end
          mCnt[i] = sum;
        end
      end
      if (wrOn && paddr == 12'h018) begin
        mFlag = mFlag & ~pwdata[3:0];
        if (pwdata[31]) mCflag = 0;
      end
      mFlag = mFlag | setF;
      if (cycClr) mCyc = 0;
      else if (run && mCen) begin
        mCyc = mCyc + 1;
        if (mCyc == (64'd1 << CYCW)) begin mCyc = 0; mCflag = 1; end
      end
      if (wrOn) begin
        case (paddr)
          12'h004: begin mGlob = pwdata[0]; mMode = pwdata[21:20]; end
          12'h008: begin mEn = mEn | pwdata[3:0]; mCen = mCen | pwdata[31]; end
          12'h00C: begin mEn = mEn & ~pwdata[3:0]; mCen = mCen & !pwdata[31]; end
          12'h200: mType[0] = pwdata[7:0];
          12'h204: mType[1] = pwdata[7:0];
          12'h208: mType[2] = pwdata[7:0];
          12'h20C: mType[3] = pwdata[7:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(logic [11:0] a);
    logic [31:0] r = '0;
    case (a)
      12'h004: begin r[0] = mGlob; r[21:20] = mMode; end
      12'h008, 12'h00C: begin r[3:0] = mEn; r[31] = mCen; end
      12'h018: begin r[3:0] = mFlag; r[31] = mCflag; end
      12'h034: r = mCnt[0][31:0];
      12'h038: r = mCnt[1][31:0];
      12'h03C: r = mCnt[2][31:0];
      12'h040: r = mCnt[3][31:0];
      12'h044: r[7:0] = mCnt[3][39:32];
      12'h048: r = mCyc[31:0];
      12'h200: r[7:0] = mType[0];
      12'h204: r[7:0] = mType[1];
      12'h208: r[7:0] = mType[2];
      12'h20C: r[7:0] = mType[3];
      default: ;
    endcase
    return r;
  endfunction

  function automatic string tagOf(logic [11:0] a);
    case (a)
      12'h004: return "R1";
      12'h008, 12'h00C: return "R2";
      12'h018: return "R8";
      12'h034, 12'h038, 12'h200, 12'h204, 12'h208: return "R4";
      12'h03C, 12'h040, 12'h044, 12'h20C: return "R5";
      12'h048: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic apbWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic readCheck(logic [11:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    exp = expRead(a);
    checks++;
    if (prdata !== exp) begin
      errors++;
      $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h", tag, a, prdata, exp);
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readCounters(string tag);
    readCheck(12'h034, tag); readCheck(12'h038, tag); readCheck(12'h03C, tag);
    readCheck(12'h040, tag); readCheck(12'h044, tag); readCheck(12'h048, tag);
  endtask

  localparam logic [11:0] ADDRS [16] = '{12'h004, 12'h008, 12'h00C, 12'h018, 12'h034,
    12'h038, 12'h03C, 12'h040, 12'h044, 12'h048, 12'h200, 12'h204, 12'h208, 12'h20C,
    12'h02C, 12'h100};

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: everything reads zero after reset
    foreach (ADDRS[i]) readCheck(ADDRS[i], "R10");

    // R1: enable and mode read back, reset bits read zero
    apbWrite(12'h004, 32'h0010_0001); readCheck(12'h004, "R1");
    apbWrite(12'h004, 32'h0000_0006); readCheck(12'h004, "R1");

    // R2: set/clear registers, zero bits keep state
    apbWrite(12'h008, 32'h8000_0005); readCheck(12'h008, "R2");
    apbWrite(12'h00C, 32'h0000_0004); readCheck(12'h00C, "R2");
    apbWrite(12'h008, 32'h0000_0000); readCheck(12'h008, "R2");
    apbWrite(12'h008, 32'h8000_000F); readCheck(12'h00C, "R2");

    // R4/R5: event codes, combined mode on counter 3, 0x22 ignored on counter 2
    apbWrite(12'h200, 32'h04); apbWrite(12'h204, 32'h05);
    apbWrite(12'h208, 32'h22); apbWrite(12'h20C, 32'h22);
    readCheck(12'h208, "R4"); readCheck(12'h20C, "R5");
    apbWrite(12'h004, 32'h0000_0007);  // start, clear all
    evMode = 1; idle(5); evMode = 2; idle(3); evMode = 3; idle(2); evMode = 0;
    apbWrite(12'h004, 32'h0000_0000);  // freeze
    readCheck(12'h034, "R4"); readCheck(12'h038, "R4");
    readCheck(12'h03C, "R5"); readCheck(12'h040, "R5"); readCheck(12'h044, "R5");
    readCheck(12'h048, "R6");

    // R3: frozen under global disable, non-manual mode, or own enable off
    evMode = 1; idle(6); readCounters("R3");
    apbWrite(12'h004, 32'h0020_0001); idle(6); readCounters("R3");
    apbWrite(12'h00C, 32'h0000_0002); apbWrite(12'h004, 32'h0000_0001);
    idle(6); apbWrite(12'h004, 32'h0); readCounters("R3");
    apbWrite(12'h008, 32'h0000_0002);

    // R8: wrap the 8-bit counters and the 10-bit cycle counter
    apbWrite(12'h004, 32'h0000_0001);
    evMode = 2; idle(300); readCheck(12'h018, "R8");
    apbWrite(12'h018, 32'h0000_0001); readCheck(12'h018, "R8");
    evMode = 1; idle(800); readCheck(12'h018, "R8"); readCheck(12'h048, "R6");
    apbWrite(12'h018, 32'h8000_000F); readCheck(12'h018, "R8");
    evMode = 0;

    // R7: selective and global clears
    apbWrite(12'h004, 32'h0);
    apbWrite(12'h02C, 32'h8000_0002); readCounters("R7");
    apbWrite(12'h004, 32'h0000_0002); readCounters("R7");

    // R9: unmapped and unimplemented offsets
    apbWrite(12'h100, 32'hFFFF_FFFF); apbWrite(12'h01C, 32'hFFFF_FFFF);
    apbWrite(12'h030, 32'hFFFF_FFFF); apbWrite(12'h3FC, 32'hFFFF_FFFF);
    readCheck(12'h100, "R9"); readCheck(12'h01C, "R9"); readCheck(12'h02C, "R9");
    readCheck(12'h008, "R9"); readCheck(12'h004, "R9"); readCounters("R9");

    // random traffic checked against the model
    evMode = 4;
    apbWrite(12'h004, 32'h0000_0001);
    for (int k = 0; k < 400; k++) begin
      int          op;
      logic [31:0] d;
      logic [11:0] a;
      op = $urandom_range(0, 11);
      d  = $urandom;
      case (op)
        0: begin
          d = d & 32'h0030_0007;
          if ($urandom_range(0, 3) != 0) d[21:20] = 2'd0;
          if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
          apbWrite(12'h004, d);
        end
        1: apbWrite(12'h008, d);
        2: apbWrite(12'h00C, d & 32'h8000_0005);
        3: begin
          a = 12'h200 + 12'(4 * $urandom_range(0, 3));
          case ($urandom_range(0, 3))
            0: d = 32'h04;
            1: d = 32'h05;
            2: d = 32'h22;
            default: ;
          endcase
          apbWrite(a, d);
        end
        4: apbWrite(12'h02C, d & 32'h8000_0003);
        5: apbWrite(12'h018, d);
        default: begin
          a = ADDRS[$urandom_range(0, 15)];
          readCheck(a, tagOf(a));
        end
      endcase
    end
    evMode = 0;
    apbWrite(12'h004, 32'h0);
    readCounters("R5"); readCheck(12'h018, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule